// File: doc/BRIEF.md
# Gapped-Clock Serial Transmitter with Data Enable

This block converts a stream of bytes into a single serial line. Bytes arrive on a valid/ready handshake and leave most significant bit first, one bit for each qualifying rising edge of the line clock. The line clock may be gapped. A clock-enable input models the gaps: when it is low, nothing inside the block moves.

An external data-enable pin can pause the bit flow for framers that cannot gap their clock. It is sampled on one enabled edge and takes effect on the next one. A configuration pin sets whether the enable is active high or active low. When byte-framed mode is on, a strobe marks the last bit of each byte on the line, so a downstream serial-to-parallel stage can find byte boundaries. When no byte is waiting at a byte boundary, the line idles at all ones.

Back-pressure rules: `s_ready` is a combinational function of `clk_en`, the stored enable sample, the bits still to send and reset. It never depends on `s_valid`. A byte transfers on the rising edge where `s_valid` and `s_ready` are both high. The source must hold `s_valid` and `s_data` steady until that edge.

Top module: `ser_tx_gated`

## Requirements
- R1: A synchronous reset drives `ser_out` to 1 and `byte_sync` to 0. `s_ready` stays 0 until one enabled edge after reset has sampled the data-enable. Any partly sent byte is dropped.
- R2: On the edge that accepts a byte, `ser_out` takes the byte's most significant bit (bit 7 for the default width).
- R3: The remaining bits follow in descending bit order, one per enabled edge on which the stored enable sample is active.
- R4: While `clk_en` is low, `ser_out` and `byte_sync` hold, and the data-enable pin is not sampled.
- R5: A byte offered while the last bit of the previous byte is on the line is accepted on the next qualifying edge, with no idle bit between the two bytes.
- R6: The data-enable level sampled at one enabled edge decides whether the next enabled edge advances the line. A change on the pin therefore shows up one enabled edge late.
- R7: With `den_pol` = 1 the data-enable is active high. With `den_pol` = 0 it is active low.
- R8: With `framed_mode` = 1, `byte_sync` is 1 exactly while the final bit of a byte is on the line. After any enabled edge with `framed_mode` = 0, it is 0.
- R9: If a qualifying edge finds no bits left and `s_valid` low, `ser_out` becomes 1 and `byte_sync` becomes 0.
- R10: `s_ready` is 1 only when `clk_en` is 1, the stored enable sample is active and no bits of the current byte remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Clock qualifier that models the gapped clock |
| s_valid | input | 1 | Byte offered |
| s_data | input | WIDTH | Byte to send, MSB first |
| s_ready | output | 1 | Byte will be taken at this edge |
| den | input | 1 | External data-enable pin |
| den_pol | input | 1 | 1 = enable active high, 0 = active low |
| framed_mode | input | 1 | Enables the byte-sync strobe |
| ser_out | output | 1 | Serial data line |
| byte_sync | output | 1 | Last-bit-of-byte strobe |

## Verification
Every line result is due one rising edge after the enabled edge that causes it. A change on the data-enable pin is due two enabled edges after it is driven, because the first edge only stores the sample. The bench drives inputs at falling edges and reads `ser_out` and `byte_sync` at the next falling edge, so each read sees exactly one rising edge of effect. `s_ready` is read a short settle delay after the falling-edge drive, before the edge that would use it. In the enable tests the bench inserts the extra enabled edge explicitly and checks that the line holds through it.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  // Action chosen for one clock edge
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_SHIFT = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_IDLE  = 2'd3
  } act_e;
endpackage

// File: rtl/sertx_den_gate.sv
module sertx_den_gate (
  input  logic clk,
  input  logic rst,
  input  logic clk_en,
  input  logic den,
  input  logic den_pol,
  output logic allow_q
);
  // Sample taken one enabled edge ahead of the bit it governs
  always_ff @(posedge clk) begin
    if (rst)         allow_q <= 1'b0;
    else if (clk_en) allow_q <= (den == den_pol);
  end
endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
(
  input  logic rst,
  input  logic clk_en,
  input  logic allow_q,
  input  logic empty,
  input  logic s_valid,
  output act_e act,
  output logic s_ready
);
  logic go;

  always_comb begin
    go      = clk_en & allow_q & ~rst;
    s_ready = go & empty;
    act     = ACT_HOLD;
    if (go) begin
      if (!empty)       act = ACT_SHIFT;
      else if (s_valid) act = ACT_LOAD;
      else              act = ACT_IDLE;
    end
  end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
#(
  parameter int   WIDTH    = 8,
  parameter logic IDLE_BIT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  act_e             act,
  input  logic [WIDTH-1:0] load_data,
  output logic             ser_out,
  output logic             empty,
  output logic             last_nxt
);
  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WIDTH - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic             LOAD_IS_LAST = (WIDTH == 1);

  logic [WIDTH-1:0] sh_q;
  logic [CNT_W-1:0] cnt_q;   // bits still to send after the one on the line
  logic             ser_q;
  logic             last_q;  // the bit on the line ends a byte

  assign ser_out = ser_q;
  assign empty   = (cnt_q == '0);

  always_comb begin
    unique case (act)
      ACT_LOAD:  last_nxt = LOAD_IS_LAST;
      ACT_SHIFT: last_nxt = (cnt_q == CNT_ONE);
      ACT_IDLE:  last_nxt = 1'b0;
      default:   last_nxt = last_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      ser_q  <= IDLE_BIT;
      last_q <= 1'b0;
    end else begin
      last_q <= last_nxt;
      unique case (act)
        ACT_LOAD: begin
          ser_q <= load_data[WIDTH-1];
          sh_q  <= load_data << 1;
          cnt_q <= CNT_FULL;
        end
        ACT_SHIFT: begin
          ser_q <= sh_q[WIDTH-1];
          sh_q  <= sh_q << 1;
          cnt_q <= cnt_q - CNT_ONE;
        end
        ACT_IDLE: ser_q <= IDLE_BIT;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sertx_mark.sv
module sertx_mark (
  input  logic clk,
  input  logic rst,
  input  logic clk_en,
  input  logic framed_mode,
  input  logic last_nxt,
  output logic byte_sync
);
  always_ff @(posedge clk) begin
    if (rst)         byte_sync <= 1'b0;
    else if (clk_en) byte_sync <= framed_mode & last_nxt;
  end
endmodule

// File: rtl/ser_tx_gated.sv
module ser_tx_gated
  import sertx_pkg::*;
#(
  parameter int   WIDTH    = 8,
  parameter logic IDLE_BIT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_en,
  input  logic             s_valid,
  input  logic [WIDTH-1:0] s_data,
  output logic             s_ready,
  input  logic             den,
  input  logic             den_pol,
  input  logic             framed_mode,
  output logic             ser_out,
  output logic             byte_sync
);
  logic allow_q;
  logic empty;
  logic last_nxt;
  act_e act;

  sertx_den_gate u_gate (
    .clk(clk), .rst(rst), .clk_en(clk_en),
    .den(den), .den_pol(den_pol), .allow_q(allow_q)
  );

  sertx_ctrl u_ctrl (
    .rst(rst), .clk_en(clk_en), .allow_q(allow_q), .empty(empty),
    .s_valid(s_valid), .act(act), .s_ready(s_ready)
  );

  sertx_shift #(.WIDTH(WIDTH), .IDLE_BIT(IDLE_BIT)) u_shift (
    .clk(clk), .rst(rst), .act(act), .load_data(s_data),
    .ser_out(ser_out), .empty(empty), .last_nxt(last_nxt)
  );

  sertx_mark u_mark (
    .clk(clk), .rst(rst), .clk_en(clk_en), .framed_mode(framed_mode),
    .last_nxt(last_nxt), .byte_sync(byte_sync)
  );
endmodule

// File: rtl/ser_tx_gated_chk.sv
module ser_tx_gated_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             clk_en,
  input logic             s_valid,
  input logic [WIDTH-1:0] s_data,
  input logic             s_ready,
  input logic             den,
  input logic             den_pol,
  input logic             framed_mode,
  input logic             ser_out,
  input logic             byte_sync
);
  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ser_out && !byte_sync && !s_ready));

  assert_msb_on_load_R2: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) |=> (ser_out == $past(s_data[WIDTH-1])) &&
                             ((WIDTH == 1) || !byte_sync));

  assert_hold_when_gated_R4: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> ($stable(ser_out) && $stable(byte_sync)));

  assert_no_sync_unframed_R8: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !framed_mode) |=> !byte_sync);

  assert_idle_on_underrun_R9: assert property (@(posedge clk) disable iff (rst)
    (clk_en && s_ready && !s_valid) |=> (ser_out && !byte_sync));

  assert_ready_needs_enable_R10: assert property (@(posedge clk) disable iff (rst)
    s_ready |-> clk_en);
endmodule

bind ser_tx_gated ser_tx_gated_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/test_ser_tx_gated.sv
`timescale 1ns/1ps
module test_ser_tx_gated;
  logic       clk = 1'b0;
  logic       rst, clk_en, s_valid, den, den_pol, framed_mode;
  logic [7:0] s_data;
  logic       s_ready, ser_out, byte_sync;
  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  ser_tx_gated i_ser_tx_gated (
    .clk(clk), .rst(rst), .clk_en(clk_en), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .den(den), .den_pol(den_pol), .framed_mode(framed_mode),
    .ser_out(ser_out), .byte_sync(byte_sync)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic line(input string req, input logic exp_d, input logic exp_s);
    chk(ser_out === exp_d, req, "ser_out", int'(ser_out), int'(exp_d));
    chk(byte_sync === exp_s, req, "byte_sync", int'(byte_sync), int'(exp_s));
  endtask

  // Offer a byte, wait for acceptance, then follow all bits on the line
  task automatic send_byte(input logic [7:0] b, input string req,
                           input bit ready_now);
    s_valid = 1'b1;
    s_data  = b;
    clk_en  = 1'b1;
    #0.5;
    if (ready_now) chk(s_ready === 1'b1, "R5", "ready at boundary", int'(s_ready), 1);
    for (int k = 0; k < 20 && !s_ready; k++) begin
      cyc();
      #0.5;
    end
    cyc();
    s_valid = 1'b0;
    line("R2", b[7], 1'b0);
    for (int i = 6; i >= 0; i--) begin
      #0.5;
      chk(s_ready === 1'b0, "R10", "ready mid-byte", int'(s_ready), 0);
      cyc();
      line(req, b[i], framed_mode && (i == 0));
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; clk_en = 1'b1; s_valid = 1'b0; s_data = '0;
    den = 1'b1; den_pol = 1'b1; framed_mode = 1'b1;
    cyc(); cyc(); cyc();
    rst = 1'b0;
    #0.5;
    line("R1", 1'b1, 1'b0);
    chk(s_ready === 1'b0, "R1", "ready before sample", int'(s_ready), 0);
    cyc();
    #0.5;
    chk(s_ready === 1'b1, "R10", "ready when idle", int'(s_ready), 1);
  endtask

  task automatic t_stream();
    send_byte(8'hA5, "R3", 1'b0);
    send_byte(8'h3C, "R3", 1'b1);
    cyc();
    line("R9", 1'b1, 1'b0);
    cyc();
    line("R9", 1'b1, 1'b0);
  endtask

  task automatic t_gapped();
    logic [7:0] b = 8'h96;
    s_valid = 1'b1; s_data = b; clk_en = 1'b0;
    #0.5;
    chk(s_ready === 1'b0, "R10", "ready while gated", int'(s_ready), 0);
    cyc();
    line("R4", 1'b1, 1'b0);
    clk_en = 1'b1;
    cyc();
    s_valid = 1'b0;
    line("R2", b[7], 1'b0);
    for (int i = 6; i >= 0; i--) begin
      clk_en = 1'b0; den = 1'b0;       // inactive level, must not be sampled
      cyc();
      line("R4", b[i+1], framed_mode && (i == 6) ? 1'b0 : 1'b0);
      clk_en = 1'b1; den = 1'b1;
      cyc();
      line("R3", b[i], i == 0);
    end
    clk_en = 1'b0;
    cyc();
    line("R4", b[0], 1'b1);
    clk_en = 1'b1;
    cyc();
    line("R9", 1'b1, 1'b0);
  endtask

  task automatic t_den();
    logic [7:0] b = 8'h5A;
    den_pol = 1'b0; den = 1'b0;         // active low, currently active
    s_valid = 1'b1; s_data = b;
    #0.5;
    chk(s_ready === 1'b1, "R7", "ready with active-low enable", int'(s_ready), 1);
    cyc();
    s_valid = 1'b0;
    line("R2", b[7], 1'b0);
    den = 1'b1;                         // inactive for active-low
    cyc();
    line("R6", b[6], 1'b0);             // earlier sample still allowed this edge
    cyc();
    line("R7", b[6], 1'b0);             // now held
    den = 1'b0;
    cyc();
    line("R6", b[6], 1'b0);             // still held, sample just taken
    for (int i = 5; i >= 0; i--) begin
      cyc();
      line("R3", b[i], i == 0);
    end
    den_pol = 1'b1; den = 1'b1;
    cyc();
    line("R9", 1'b1, 1'b0);
  endtask

  task automatic t_unframed();
    framed_mode = 1'b0;
    send_byte(8'hE1, "R8", 1'b0);
    framed_mode = 1'b1;
  endtask

  task automatic t_mid_reset();
    s_valid = 1'b1; s_data = 8'h00;
    #0.5;
    cyc();
    s_valid = 1'b0;
    line("R2", 1'b0, 1'b0);
    cyc();
    rst = 1'b1;
    cyc();
    rst = 1'b0;
    #0.5;
    line("R1", 1'b1, 1'b0);
    chk(s_ready === 1'b0, "R1", "ready after mid-byte reset", int'(s_ready), 0);
    cyc();
    line("R1", 1'b1, 1'b0);
    send_byte(8'h81, "R3", 1'b0);
  endtask

  initial begin
    t_reset();
    t_stream();
    t_gapped();
    t_den();
    t_unframed();
    t_mid_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule